// File: doc/BRIEF.md
# Modulo Alarm Timer with Overflow Flag

This block is a memory-mapped up-counting timer for one-shot alarm wakeups. A 16-bit counter advances on prescaled ticks of a slow reference. The reference is supplied as a single-cycle enable pulse, `ref_tick`, in the system clock domain. When the counter equals the programmed modulo value, the next tick reloads it from a programmable start value instead of incrementing it. That step raises a sticky overflow flag. To make an alarm fire N ticks after it is armed, software writes zero to the start value and N-1 to the modulo value, writes any value to the counter to load it, and then selects the reference as the clock source.

The register port has single-cycle write and read strobes, a byte address and 32-bit data. Read data is combinational from the address. The overflow flag is tracked by a three-state machine. In FLG_CLEAR the flag is 0. FLG_CLEAR goes to FLG_PENDING on an overflow. FLG_PENDING goes to FLG_ARMED when the control register is read while the flag shows 1. FLG_ARMED goes to FLG_CLEAR on a control write with the flag bit at 0. A fresh overflow in FLG_ARMED returns the machine to FLG_PENDING, and an overflow in FLG_PENDING keeps it there. The level interrupt output is high while the flag is set and the interrupt-enable bit is 1.

Top module: `alarm_timer`

## Requirements
- R1: Register offsets are: control at 0x00, counter at 0x04, modulo at 0x08 and start value at 0x4C. Any other offset reads 0. The counter, modulo and start registers hold 16 bits in data bits 15:0, and bits 31:16 read 0. After reset every register reads 0 and `irq` is 0.
- R2: On each tick, the counter increments while it differs from the modulo value. On the tick after it equals the modulo value, it loads the start value.
- R3: The overflow flag (control bit 7) sets exactly on the tick where the counter steps from the modulo value to the start value.
- R4: A write of any data to the counter loads it with the start value. This write takes precedence over a tick in the same cycle.
- R5: Clock-source field control[4:3]: value 2 selects `ref_tick`. Values 0, 1 and 3 select no clock, and the counter holds its value.
- R6: Prescale field control[2:0] = p: one tick occurs per 2^p `ref_tick` pulses, so p=7 gives 128. The divider restarts from zero whenever the clock source is 0. The first tick after re-enabling therefore needs a full 2^p pulses.
- R7: `irq` is high exactly while the flag and the enable bit control[6] are both 1. Clearing the enable bit drops `irq` and leaves the flag set.
- R8: The flag clears only when control is written with bit 7 at 0 after a read that returned the flag as 1. A write of 0 without that prior read, or a write of 1, has no effect on the flag.
- R9: An overflow in the same cycle as a clearing write leaves the flag at 1.
- R10: An overflow after the arming read and before the clearing write cancels the arming, so the next write of 0 leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse standing in for the fixed low-frequency reference |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Level interrupt: flag and enable both set |

## Verification
The assertions assume that the strobes are single-cycle qualified events. They also assume that a write and a read never target the same register in one cycle, and that `ref_tick` is a clean pulse sampled only at the clock edge. The stimulus drives each access for exactly one cycle, launched on the falling edge. Only the same-cycle tests raise `ref_tick` together with a write. The prescale tests change the prescale field only while the source is 0. This keeps the divider inside the new limit and holds the tick count per period exact.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // Control register field positions
    localparam int PS_LSB   = 0;
    localparam int SRC_LSB  = 3;
    localparam int SRC_W    = 2;
    localparam int IE_BIT   = 6;
    localparam int FLAG_BIT = 7;

    // Clock-source encodings
    localparam logic [SRC_W-1:0] SRC_NONE = 2'd0;
    localparam logic [SRC_W-1:0] SRC_REF  = 2'd2;

    // Register offsets
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_CNT   = 'h04;
    localparam int OFF_MOD   = 'h08;
    localparam int OFF_START = 'h4C;

    typedef enum logic [1:0] {
        FLG_CLEAR   = 2'd0,
        FLG_PENDING = 2'd1,
        FLG_ARMED   = 2'd2
    } flag_state_e;

endpackage

// File: rtl/alarm_prescale.sv
module alarm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_tick,
    input  logic            src_ref,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   lim_full;
    logic [DIV_W:0]   lim_m1;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim_full = {{DIV_W{1'b0}}, 1'b1} << ps;
        lim_m1   = lim_full - {{DIV_W{1'b0}}, 1'b1};
        lim      = lim_m1[DIV_W-1:0];
    end

    assign tick = src_ref && ref_tick && (div_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (src_ref && ref_tick) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic at_mod;

    assign at_mod = (count == mod_val);
    assign ovf    = tick && !load && at_mod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= start_val;
        end else if (tick) begin
            count <= at_mod ? start_val : count + 1'b1;
        end
    end
endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic rd_ctrl,
    input  logic clr_wr,
    output logic flag,
    output logic armed
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (ovf) state_d = FLG_PENDING;
            FLG_PENDING: if (!ovf && rd_ctrl) state_d = FLG_ARMED;
            FLG_ARMED: begin
                if (ovf)         state_d = FLG_PENDING;
                else if (clr_wr) state_d = FLG_CLEAR;
            end
            default:     state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag  = (state_q != FLG_CLEAR);
        armed = (state_q == FLG_ARMED);
    end
endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic sel_ctrl, sel_cnt, sel_mod, sel_start;
    logic wr_ctrl, rd_ctrl, clr_wr, src_clr;

    logic [PS_W-1:0]  ps_q;
    logic [SRC_W-1:0] src_q;
    logic             ie_q;
    logic [CNT_W-1:0] mod_q, start_q, cnt_q;
    logic             tick, ovf, flag, armed;
    logic             unused_wdata;

    assign sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
    assign sel_cnt   = (addr == ADDR_W'(OFF_CNT));
    assign sel_mod   = (addr == ADDR_W'(OFF_MOD));
    assign sel_start = (addr == ADDR_W'(OFF_START));

    assign wr_ctrl = wr_en && sel_ctrl;
    assign rd_ctrl = rd_en && sel_ctrl && flag;
    assign clr_wr  = wr_ctrl && !wdata[FLAG_BIT];
    assign src_clr = (src_q == SRC_NONE) ||
                     (wr_ctrl && wdata[SRC_LSB +: SRC_W] == SRC_NONE);
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q    <= '0;
            src_q   <= SRC_NONE;
            ie_q    <= 1'b0;
            mod_q   <= '0;
            start_q <= '0;
        end else if (wr_en) begin
            if (sel_ctrl) begin
                ps_q  <= wdata[PS_LSB +: PS_W];
                src_q <= wdata[SRC_LSB +: SRC_W];
                ie_q  <= wdata[IE_BIT];
            end
            if (sel_mod)   mod_q   <= wdata[CNT_W-1:0];
            if (sel_start) start_q <= wdata[CNT_W-1:0];
        end
    end

    alarm_prescale #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .src_ref (src_q == SRC_REF),
        .clr     (src_clr),
        .ps      (ps_q),
        .tick    (tick)
    );

    alarm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_en && sel_cnt),
        .mod_val  (mod_q),
        .start_val(start_q),
        .count    (cnt_q),
        .ovf      (ovf)
    );

    alarm_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (ovf),
        .rd_ctrl(rd_ctrl),
        .clr_wr (clr_wr),
        .flag   (flag),
        .armed  (armed)
    );

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[PS_LSB +: PS_W]   = ps_q;
            rdata[SRC_LSB +: SRC_W] = src_q;
            rdata[IE_BIT]           = ie_q;
            rdata[FLAG_BIT]         = flag;
        end else if (sel_cnt) begin
            rdata[CNT_W-1:0] = cnt_q;
        end else if (sel_mod) begin
            rdata[CNT_W-1:0] = mod_q;
        end else if (sel_start) begin
            rdata[CNT_W-1:0] = start_q;
        end
    end

    assign irq = flag && ie_q;
endmodule

// File: rtl/alarm_timer_chk.sv
module alarm_timer_chk
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  mod_val,
    input logic [CNT_W-1:0]  start_val,
    input logic [SRC_W-1:0]  src,
    input logic              tick,
    input logic              ovf,
    input logic              flag,
    input logic              armed
);
    logic wr_cnt, wr_ctrl;
    assign wr_cnt  = wr_en && (addr == ADDR_W'(OFF_CNT));
    assign wr_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'(OFF_CNT)) |-> rdata[DATA_W-1:CNT_W] == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_cnt && (count != mod_val) |=> count == $past(count) + 1'b1);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_cnt && (count == mod_val) |=> count == $past(start_val));

    p_ovf_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    p_cnt_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> count == $past(start_val));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) && !wr_cnt |=> $stable(count));

    p_ie_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !wdata[IE_BIT] |=> !irq);

    p_blind_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !armed && wr_ctrl |=> flag);

    p_write_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && wr_ctrl && wdata[FLAG_BIT] |=> flag);
endmodule

bind alarm_timer alarm_timer_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .count    (cnt_q),
    .mod_val  (mod_q),
    .start_val(start_q),
    .src      (src_q),
    .tick     (tick),
    .ovf      (ovf),
    .flag     (flag),
    .armed    (armed)
);

// File: tb/test_alarm_timer.sv
module test_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_START = 8'h4C;

    always #4 clk = ~clk;

    alarm_timer i_alarm_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic run_ref(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
        end
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic wr_with_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; ref_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic expect_reg(input string req, input string what,
                              input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, what, d, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1", "ctrl after reset", A_CTRL, 32'h0);
        expect_reg("R1", "count after reset", A_CNT, 32'h0);
        expect_reg("R1", "modulo after reset", A_MOD, 32'h0);
        expect_reg("R1", "start after reset", A_START, 32'h0);
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
        wr(A_MOD, 32'hABCD_1234);
        expect_reg("R1", "modulo upper bits", A_MOD, 32'h0000_1234);
        expect_reg("R1", "unmapped 0x0C", 8'h0C, 32'h0);
        expect_reg("R1", "unmapped 0x50", 8'h50, 32'h0);
    endtask

    task automatic t_basic_wrap;
        wr(A_START, 0); wr(A_MOD, 4); wr(A_CNT, 32'h55);
        wr(A_CTRL, 32'h10);
        run_ref(3);
        expect_reg("R2", "count after 3 ticks", A_CNT, 3);
        run_ref(1);
        expect_reg("R3", "no flag at modulo", A_CTRL, 32'h10);
        run_ref(1);
        expect_reg("R2", "reload after modulo", A_CNT, 0);
        expect_reg("R3", "flag after wrap", A_CTRL, 32'h90);
        wr(A_CTRL, 32'h10);
        expect_reg("R8", "flag cleared after read+write0", A_CTRL, 32'h10);
    endtask

    task automatic t_start_value;
        wr(A_START, 10); wr(A_MOD, 12);
        wr(A_CNT, 32'hFFFF);
        expect_reg("R4", "count write loads start", A_CNT, 10);
        run_ref(3);
        expect_reg("R2", "wrap to start 10", A_CNT, 10);
        expect_reg("R3", "flag after wrap to start", A_CTRL, 32'h90);
        wr(A_CTRL, 32'h10);
        run_ref(1);
        wr_with_tick(A_CNT, 32'h7);
        expect_reg("R4", "write beats tick", A_CNT, 10);
    endtask

    task automatic t_hold;
        wr(A_CTRL, 32'h00);
        run_ref(5);
        expect_reg("R5", "hold with source 0", A_CNT, 10);
        wr(A_CTRL, 32'h08);
        run_ref(5);
        expect_reg("R5", "hold with source 1", A_CNT, 10);
        wr(A_CTRL, 32'h00);
    endtask

    task automatic t_prescale;
        wr(A_START, 0); wr(A_MOD, 32'hFFFF); wr(A_CNT, 0);
        wr(A_CTRL, 32'h12);
        run_ref(3);
        expect_reg("R6", "no tick before 4 pulses", A_CNT, 0);
        run_ref(1);
        expect_reg("R6", "tick at 4th pulse", A_CNT, 1);
        run_ref(8);
        expect_reg("R6", "two more ticks", A_CNT, 3);
        run_ref(2);
        wr(A_CTRL, 32'h02);
        wr(A_CTRL, 32'h12);
        run_ref(3);
        expect_reg("R6", "divider restarted", A_CNT, 3);
        run_ref(1);
        expect_reg("R6", "full period after restart", A_CNT, 4);
        wr(A_CTRL, 32'h00);
        wr(A_CTRL, 32'h17);
        run_ref(127);
        expect_reg("R6", "div128 before last pulse", A_CNT, 4);
        run_ref(1);
        expect_reg("R6", "div128 tick", A_CNT, 5);
        wr(A_CTRL, 32'h00);
    endtask

    task automatic t_irq;
        wr(A_MOD, 0); wr(A_START, 0); wr(A_CNT, 0);
        wr(A_CTRL, 32'h50);
        check("R7", "irq low before event", {31'b0, irq}, 0);
        run_ref(1);
        check("R7", "irq high on flag+enable", {31'b0, irq}, 1);
        wr(A_CTRL, 32'h10);
        check("R7", "irq low after enable cleared", {31'b0, irq}, 0);
        expect_reg("R8", "blind write0 keeps flag", A_CTRL, 32'h90);
        wr(A_CTRL, 32'h90);
        expect_reg("R8", "write1 keeps flag", A_CTRL, 32'h90);
        wr(A_CTRL, 32'hD0);
        check("R7", "irq returns when re-enabled", {31'b0, irq}, 1);
        wr(A_CTRL, 32'h50);
        check("R7", "irq low after clear", {31'b0, irq}, 0);
        expect_reg("R8", "armed clear", A_CTRL, 32'h50);
    endtask

    task automatic t_rearm;
        logic [31:0] d;
        wr(A_CTRL, 32'h10);
        run_ref(1);
        rd(A_CTRL, d);
        run_ref(1);
        wr(A_CTRL, 32'h10);
        expect_reg("R10", "new event cancels arming", A_CTRL, 32'h90);
        wr(A_CTRL, 32'h10);
        expect_reg("R10", "clears after re-read", A_CTRL, 32'h10);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        run_ref(1);
        rd(A_CTRL, d);
        wr_with_tick(A_CTRL, 32'h10);
        expect_reg("R9", "set wins over clear", A_CTRL, 32'h90);
        wr(A_CTRL, 32'h10);
        expect_reg("R9", "later clear works", A_CTRL, 32'h10);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_wrap();
        t_start_value();
        t_hold();
        t_prescale();
        t_irq();
        t_rearm();
        t_same_cycle();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule